// File: doc/BRIEF.md
# BCD Programmable Watchdog Timer

This block supervises a processor by counting down a timeout that software loads as four packed-BCD digits held in two byte registers. A 100 Hz strobe advances the count in 10 ms steps, so any period from 0.01 s to 99.99 s can be chosen. Software proves it is alive by writing either timeout register, which restarts the period from the full programmed value. A timeout of zero leaves the timer idle. After reset both registers are zero, so the watchdog starts out disabled.

When the count runs out, a sticky timeout flag is raised and the timer reloads itself. An enable bit and a steering bit decide what else happens. The timeout can raise a level interrupt request. It can instead fire an active-low reset pulse of fixed length, and in that case the enable bit clears itself. Register decoding is reduced to write strobes, and interrupts from other sources are merged outside the block.

Top module: `wdt_bcd`

## Requirements
- R1: The timeout in ticks equals the decimal value of the digits {hi[7:4], hi[3:0], lo[7:4], lo[3:0]}. Here hi holds tens and units of seconds and lo holds tenths and hundredths. The flag rises on the N-th tick_i pulse after the reloading write.
- R2: Writing 60h to lo and 00h to hi gives a period of 60 ticks (600 ms).
- R3: Every write strobe to lo or hi reloads the count from the full new {hi, lo} value. The current period is abandoned.
- R4: While both registers hold 00h, no timeout occurs. After reset, both registers are 00h, the enable bit is 0, flag_o is 0 and rst_n_o is 1.
- R5: On a timeout, flag_o is set whatever the enable and steering bits hold. The count reloads, so the next timeout follows after another full period with no new write.
- R6: With enable 0, a timeout sets only the flag. irq_o stays 0 and rst_n_o stays 1 whatever the steering bit holds.
- R7: With enable 1 and steering 0, irq_o is 1 while the flag is set, and rst_n_o stays 1.
- R8: With enable 1 and steering 1, a timeout drives rst_n_o low and clears the enable bit from the following cycle. irq_o stays 0, and later timeouts fire no further pulse.
- R9: A flag_clr_i strobe clears the flag. If a timeout lands in the same cycle, the flag stays set.
- R10: The reset pulse lasts exactly RST_TICKS tick_i pulses after the firing one. RST_TICKS must lie between 4 and 20 (40 ms to 200 ms).
- R11: The count steps down digit by digit in BCD. A digit at 0 becomes 9 and borrows from the next higher digit, so periods that cross digit boundaries (10, 100, 1000, 9999 ticks) come out exact.
- R12: A control write strobe loads the enable bit from wdata_i[1] and the steering bit from wdata_i[0]. Both bits can be read back on en_o and steer_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 100 Hz time-base strobe |
| lo_wr_i | input | 1 | Write strobe for the hundredths/tenths register |
| hi_wr_i | input | 1 | Write strobe for the seconds/tens register |
| ctl_wr_i | input | 1 | Write strobe for enable (bit 1) and steering (bit 0) |
| wdata_i | input | 8 | Write data |
| flag_clr_i | input | 1 | Clears the timeout flag |
| flag_o | output | 1 | Sticky timeout flag |
| en_o | output | 1 | Enable bit |
| steer_o | output | 1 | Steering bit: 0 interrupt, 1 reset pulse |
| irq_o | output | 1 | Interrupt request, active high |
| rst_n_o | output | 1 | Reset pulse output, active low |

## Verification
A write strobe sampled at one rising edge reloads the count at that same edge. A timeout is decided at the rising edge that carries the last tick. The flag, the interrupt, the cleared enable bit and the low reset output all appear right after that edge. The pulse returns high right after the edge carrying the RST_TICKS-th following tick. The bench drives every input just after a falling edge and reads every output at the next falling edge, so each result is read one half clock after the edge that makes it. Periods are measured by counting tick strobes up to the first falling edge at which the flag reads 1. The expected tick counts are worked out from the BCD digits in the bench.

// File: rtl/wdt_bcd_pkg.sv
package wdt_bcd_pkg;
   localparam int unsigned BCD_W      = 4;
   localparam int unsigned REG_W      = 8;
   localparam int unsigned TMO_DIGITS = 4;
   localparam int unsigned TMO_W      = BCD_W * TMO_DIGITS;

   typedef logic [BCD_W-1:0] bcd_digit_t;
   typedef logic [REG_W-1:0] wd_reg_t;
   typedef logic [TMO_W-1:0] tmo_t;

   typedef struct packed {
      logic en;
      logic steer;
   } wd_ctl_t;

   function automatic bcd_digit_t bcd_dec(input bcd_digit_t d);
      return (d == '0) ? bcd_digit_t'(9) : bcd_digit_t'(d - 1'b1);
   endfunction
endpackage

// File: rtl/wdt_bcd_down.sv
module wdt_bcd_down
   import wdt_bcd_pkg::*;
#(
   parameter int unsigned DIGITS = TMO_DIGITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 ld_en_i,
   input  logic [4*DIGITS-1:0]  ld_val_i,
   input  logic [4*DIGITS-1:0]  rl_val_i,
   output logic                 expire_o,
   output logic [4*DIGITS-1:0]  cnt_o
);
   localparam int unsigned W = BCD_W * DIGITS;
   localparam logic [W-1:0] ONE = W'(1);

   initial begin
      if (DIGITS < 1) $fatal(1, "wdt_bcd_down: DIGITS must be at least 1");
   end

   logic [W-1:0]      cnt_q;
   logic [W-1:0]      dec_val;
   logic [DIGITS-1:0] brw;

   assign brw[0] = 1'b1;

   generate
      for (genvar g = 0; g < DIGITS; g++) begin : g_dig
         bcd_digit_t dig;
         assign dig = cnt_q[BCD_W*g +: BCD_W];
         assign dec_val[BCD_W*g +: BCD_W] = brw[g] ? bcd_dec(dig) : dig;
         if (g + 1 < DIGITS) begin : g_brw
            assign brw[g+1] = brw[g] & (dig == '0);
         end
      end
   endgenerate

   assign expire_o = tick_i & ~ld_en_i & (cnt_q == ONE);
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (ld_en_i)                   cnt_q <= ld_val_i;
      else if (expire_o)                  cnt_q <= rl_val_i;
      else if (tick_i && cnt_q != '0)     cnt_q <= dec_val;
   end

   AST_BCD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !ld_en_i && cnt_q > ONE) |=> (cnt_q < $past(cnt_q))); // R11
   AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en_i |=> (cnt_q == $past(ld_val_i))); // R3
   AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> (cnt_q == $past(rl_val_i))); // R5
endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
   parameter int unsigned TICKS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic fire_i,
   output logic active_o
);
   localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);

   initial begin
      if (TICKS < 1) $fatal(1, "wdt_rst_stretch: TICKS must be at least 1");
   end

   generate
      if (TICKS == 1) begin : g_single
         logic act_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      act_q <= 1'b0;
            else if (fire_i) act_q <= 1'b1;
            else if (tick_i) act_q <= 1'b0;
         end
         assign active_o = act_q;
      end else begin : g_count
         logic [CW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      left_q <= '0;
            else if (fire_i)                 left_q <= CW'(TICKS);
            else if (tick_i && left_q != '0) left_q <= left_q - 1'b1;
         end
         assign active_o = (left_q != '0);
      end
   endgenerate

   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> active_o); // R10
   AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !tick_i && !fire_i) |=> active_o); // R10
   AST_PULSE_NO_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_o && !fire_i) |=> !active_o); // R10
endmodule

// File: rtl/wdt_bcd.sv
module wdt_bcd
   import wdt_bcd_pkg::*;
#(
   parameter int unsigned RST_TICKS     = 10,
   parameter int unsigned RST_MIN_TICKS = 4,
   parameter int unsigned RST_MAX_TICKS = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       lo_wr_i,
   input  logic       hi_wr_i,
   input  logic       ctl_wr_i,
   input  logic [7:0] wdata_i,
   input  logic       flag_clr_i,
   output logic       flag_o,
   output logic       en_o,
   output logic       steer_o,
   output logic       irq_o,
   output logic       rst_n_o
);
   initial begin
      if (RST_TICKS < RST_MIN_TICKS || RST_TICKS > RST_MAX_TICKS)
         $fatal(1, "wdt_bcd: RST_TICKS outside the allowed pulse window");
      if (REG_W * 2 != TMO_W)
         $fatal(1, "wdt_bcd: two registers must cover all timeout digits");
   end

   wd_reg_t lo_q, hi_q;
   wd_ctl_t ctl_q;
   logic    flag_q;
   logic    ld_en, expire, fire_rst, pulse_on;
   tmo_t    ld_val, rl_val, cnt;

   assign ld_en  = lo_wr_i | hi_wr_i;
   assign ld_val = {hi_wr_i ? wdata_i : hi_q, lo_wr_i ? wdata_i : lo_q};
   assign rl_val = {hi_q, lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (lo_wr_i) lo_q <= wdata_i;
         if (hi_wr_i) hi_q <= wdata_i;
      end
   end

   wdt_bcd_down #(.DIGITS(TMO_DIGITS)) u_down (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .ld_en_i  (ld_en),
      .ld_val_i (ld_val),
      .rl_val_i (rl_val),
      .expire_o (expire),
      .cnt_o    (cnt)
   );

   assign fire_rst = expire & ctl_q.en & ctl_q.steer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         if (fire_rst)      ctl_q.en <= 1'b0;
         else if (ctl_wr_i) ctl_q.en <= wdata_i[1];
         if (ctl_wr_i)      ctl_q.steer <= wdata_i[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (expire)     flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
   end

   wdt_rst_stretch #(.TICKS(RST_TICKS)) u_stretch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .fire_i   (fire_rst),
      .active_o (pulse_on)
   );

   assign flag_o  = flag_q;
   assign en_o    = ctl_q.en;
   assign steer_o = ctl_q.steer;
   assign irq_o   = flag_q & ctl_q.en & ~ctl_q.steer;
   assign rst_n_o = ~pulse_on;

   AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_q == '0 && hi_q == '0 && !ld_en) |=> !(flag_q && !$past(flag_q))); // R4
   AST_FLAG_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag_o); // R5
   AST_IRQ_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctl_q.en && !ctl_q.steer && !ctl_wr_i) |=> irq_o); // R7
   AST_EN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctl_q.en && ctl_q.steer) |=> (!en_o && !rst_n_o && !irq_o)); // R8
   AST_RST_ONLY_STEER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_n_o) |-> $past(ctl_q.en && ctl_q.steer && expire)); // R6
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !expire) |=> !flag_o); // R9
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_q == '0 && hi_q == '0 && !ld_en) |-> (cnt == '0)); // R4
endmodule

// File: tb/wdt_bcd_test.sv
module wdt_bcd_test;
   localparam int RST_TICKS = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0, lo_wr_i = 1'b0, hi_wr_i = 1'b0, ctl_wr_i = 1'b0;
   logic [7:0] wdata_i = '0;
   logic       flag_clr_i = 1'b0;
   logic       flag_o, en_o, steer_o, irq_o, rst_n_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   wdt_bcd #(.RST_TICKS(RST_TICKS)) uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .lo_wr_i(lo_wr_i),
      .hi_wr_i(hi_wr_i), .ctl_wr_i(ctl_wr_i), .wdata_i(wdata_i),
      .flag_clr_i(flag_clr_i), .flag_o(flag_o), .en_o(en_o),
      .steer_o(steer_o), .irq_o(irq_o), .rst_n_o(rst_n_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic tick();
      tick_i = 1'b1; cyc(); tick_i = 1'b0; cyc();
   endtask

   task automatic wr_lo(input logic [7:0] v);
      lo_wr_i = 1'b1; wdata_i = v; cyc(); lo_wr_i = 1'b0;
   endtask

   task automatic wr_hi(input logic [7:0] v);
      hi_wr_i = 1'b1; wdata_i = v; cyc(); hi_wr_i = 1'b0;
   endtask

   task automatic wr_ctl(input logic en, input logic steer);
      ctl_wr_i = 1'b1; wdata_i = {6'b0, en, steer}; cyc(); ctl_wr_i = 1'b0;
   endtask

   task automatic clr_flag();
      flag_clr_i = 1'b1; cyc(); flag_clr_i = 1'b0;
   endtask

   task automatic run_to_flag(output int n);
      n = 0;
      while (!flag_o && n < 12000) begin
         tick();
         n++;
      end
   endtask

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   task automatic measure(input int hi_v, input int lo_v, input string req);
      int n;
      wr_hi(to_bcd(hi_v));
      wr_lo(to_bcd(lo_v));
      clr_flag();
      run_to_flag(n);
      chk(req, n, hi_v * 100 + lo_v);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      int n;
      logic saw_low;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();

      // R4: reset state
      chk("R4 reset flag", flag_o, 0);
      chk("R4 reset en", en_o, 0);
      chk("R4 reset irq", irq_o, 0);
      chk("R4 reset rst_n_o", rst_n_o, 1);
      for (int i = 0; i < 30; i++) tick();
      chk("R4 idle after reset", flag_o, 0);

      // R12: control bits read back
      wr_ctl(1'b1, 1'b0);
      chk("R12 en", en_o, 1);
      chk("R12 steer", steer_o, 0);
      wr_ctl(1'b0, 1'b1);
      chk("R12 en off", en_o, 0);
      chk("R12 steer on", steer_o, 1);
      wr_ctl(1'b0, 1'b0);

      // R1 R11: sweep every low-register BCD value with hi = 00h
      for (int v = 1; v < 100; v++) measure(0, v, "R1 R11 lo sweep");
      measure(1, 0, "R11 hundred");
      measure(10, 0, "R11 thousand");
      measure(99, 99, "R1 R11 maximum");
      measure(0, 60, "R2 600ms");

      // R5: automatic reload, second period with no write
      clr_flag();
      run_to_flag(n);
      chk("R5 auto reload", n, 60);
      measure(0, 7, "R5 first");
      clr_flag();
      run_to_flag(n);
      chk("R5 second period", n, 7);

      // R3: reload by either register write
      measure(0, 20, "R3 setup");
      clr_flag();
      for (int i = 0; i < 12; i++) tick();
      chk("R3 mid period", flag_o, 0);
      wr_hi(8'h00);
      run_to_flag(n);
      chk("R3 reload by hi", n, 20);
      clr_flag();
      for (int i = 0; i < 15; i++) tick();
      wr_lo(8'h20);
      run_to_flag(n);
      chk("R3 reload by lo", n, 20);

      // R4: zero disables a running timer
      wr_lo(8'h05);
      for (int i = 0; i < 3; i++) tick();
      wr_hi(8'h00);
      wr_lo(8'h00);
      clr_flag();
      for (int i = 0; i < 40; i++) tick();
      chk("R4 zero disables", flag_o, 0);

      // R6: enable off, steering on: flag only
      wr_ctl(1'b0, 1'b1);
      wr_lo(8'h05);
      clr_flag();
      saw_low = 1'b0;
      for (int i = 0; i < 5; i++) begin tick(); if (!rst_n_o) saw_low = 1'b1; end
      chk("R6 flag", flag_o, 1);
      chk("R6 irq", irq_o, 0);
      chk("R6 no reset", saw_low, 0);

      // R7 and R9: interrupt route, flag clear, set wins
      wr_ctl(1'b1, 1'b0);
      wr_lo(8'h05);
      clr_flag();
      for (int i = 0; i < 5; i++) tick();
      chk("R7 irq", irq_o, 1);
      chk("R7 rst_n_o high", rst_n_o, 1);
      clr_flag();
      chk("R9 flag cleared", flag_o, 0);
      chk("R9 irq cleared", irq_o, 0);
      for (int i = 0; i < 4; i++) tick();
      tick_i = 1'b1; flag_clr_i = 1'b1; cyc();
      tick_i = 1'b0; flag_clr_i = 1'b0; cyc();
      chk("R9 set wins", flag_o, 1);

      // R8 and R10: reset pulse route
      wr_ctl(1'b1, 1'b1);
      wr_lo(8'h50);
      clr_flag();
      run_to_flag(n);
      chk("R8 period", n, 50);
      chk("R8 rst_n_o low", rst_n_o, 0);
      chk("R8 en cleared", en_o, 0);
      chk("R8 irq low", irq_o, 0);
      n = 0;
      while (!rst_n_o && n < 100) begin tick(); n++; end
      chk("R10 pulse length", n, RST_TICKS);
      clr_flag();
      saw_low = 1'b0;
      for (int i = 0; i < 45; i++) begin tick(); if (!rst_n_o) saw_low = 1'b1; end
      chk("R8 next flag", flag_o, 1);
      chk("R8 no second pulse", saw_low, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule